// File: doc/BRIEF.md
# Synchronous Burst SRAM with Flow-Through Reads

This block is a single-port synchronous static memory. It sits behind a processor or a cache controller and uses one data word per beat. A rising clock edge registers every control input. The block starts a burst when either of two address strobes is low. One strobe belongs to the processor and the other to the cache controller. The edge that starts a burst captures the address and also decides whether the chip is selected.

After the start, a two-bit burst counter produces the other three word addresses inside the aligned group of four. The counter moves only in cycles where the advance input is low. The burst order is chosen when the burst starts: linear (wrapping increment) or interleaved (XOR with the beat number). Read data is not registered before the outputs. The word at the current burst address reaches the data outputs in the cycle after the edge that formed that address, which gives a 2-1-1-1 burst.

Writes happen at the same edge that registers them. Each byte lane has its own select, and those selects count only while the byte-write enable is low. A separate write-all input writes every lane. The output enable gates the bus drivers without passing through the clock.

Top module: `syncBurstSram`

## Requirements
- R1: When `procStrbN` or `ctlStrbN` is low at a rising edge, that edge captures `addr` as the burst address. The chip is selected only if `csAN` is low, `csB` is high and `csCN` is low at that edge.
- R2: Read data is flow-through. In the cycle after a start edge, `dataOut` shows the word at the captured address. Each further beat's word appears in the cycle after the edge that advanced to it, so a four-beat burst takes 2-1-1-1 cycles.
- R3: With `ilvMode` low at the start edge, beat n uses low address bits (start + n) mod 4. The upper address bits never change during a burst.
- R4: With `ilvMode` high at the start edge, beat n uses low address bits (start XOR n).
- R5: An edge with both strobes high and `advanceN` high keeps the burst address, so the same word stays on `dataOut`.
- R6: When `byteWrEnN` is low, lane i (`dataIn[8i+7:8i]`) is written when `byteSelN[i]` is low. When `byteWrEnN` is high, `byteSelN` has no effect.
- R7: When `wrAllN` is low, all four lanes are written, whatever the byte selects are.
- R8: A start by `procStrbN` is always a read and writes nothing. When both strobes are low, the processor strobe decides the kind of access.
- R9: A start by `ctlStrbN` alone with a write request writes at the captured address. In a later cycle of a selected burst, a write request writes at the burst address formed at that edge, after any advance.
- R10: `busOe` is high only while the chip is selected, `outEnN` is low and the last edge did not write. `outEnN` acts without a clock, and `dataOut` is zero whenever `busOe` is low.
- R11: A start with the chip not selected turns the drivers off. No writes happen until the next selected start.
- R12: During and after reset the chip is not selected and `busOe` is low.
- R13: The burst order is held from the start edge. Changing `ilvMode` during a burst does not change the order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Word address, captured when a burst starts |
| procStrbN | input | 1 | Processor address strobe, active low, always a read |
| ctlStrbN | input | 1 | Controller address strobe, active low |
| advanceN | input | 1 | Steps the burst counter when low |
| csAN | input | 1 | Chip select, active low |
| csB | input | 1 | Chip select, active high |
| csCN | input | 1 | Chip select, active low |
| ilvMode | input | 1 | Burst order: 1 interleaved, 0 linear |
| wrAllN | input | 1 | Writes all byte lanes when low |
| byteWrEnN | input | 1 | Turns on the per-lane byte selects when low |
| byteSelN | input | BYTES | Per-lane write selects, active low |
| outEnN | input | 1 | Output enable, active low, acts without a clock |
| dataIn | input | BYTES*BYTE_W | Write data |
| dataOut | output | BYTES*BYTE_W | Read data, zero while the drivers are off |
| busOe | output | 1 | High while the block drives the data bus |

## Verification
A wrong burst counter shows up on `dataOut` one cycle after the bad advance edge. The word from the wrong neighbour in the four-word group appears, so every beat of linear and interleaved bursts from each starting offset is compared against a reference array. A lost or misrouted write stays hidden until that address is read back. For that reason each write case is followed by a read of the addresses it could have changed. A select or write-cycle flag in the wrong state shows on `busOe` in the very next cycle. An output-enable fault shows without waiting for a clock edge.

// File: rtl/syncBurstSramPkg.sv
package syncBurstSramPkg;

  // Control-to-datapath strobes for one clock edge
  typedef struct packed {
    logic load;  // capture a new burst start address
    logic step;  // advance the burst beat counter
    logic wrEn;  // write the formed address at this edge
    logic ilv;   // burst order offered with a load
  } ctrlStrobeT;

  // Low two address bits of beat 'beat' from start bits 'base'
  function automatic logic [1:0] beatLow(input logic [1:0] base,
                                         input logic [1:0] beat,
                                         input logic ilv);
    return ilv ? (base ^ beat) : (base + beat);
  endfunction

endpackage

// File: rtl/syncBurstSramCtrl.sv
module syncBurstSramCtrl
  import syncBurstSramPkg::*;
#(
  parameter int BYTES = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             procStrbN,
  input  logic             ctlStrbN,
  input  logic             advanceN,
  input  logic             csAN,
  input  logic             csB,
  input  logic             csCN,
  input  logic             ilvMode,
  input  logic             wrAllN,
  input  logic             byteWrEnN,
  input  logic [BYTES-1:0] byteSelN,
  input  logic             outEnN,
  output ctrlStrobeT       strb,
  output logic [BYTES-1:0] byteWe,
  output logic             busOe
);

  logic procStart;
  logic ctlStart;
  logic anyStart;
  logic chipSel;
  logic [BYTES-1:0] laneReq;
  logic wrReq;
  logic selQ;
  logic selD;
  logic wrCycQ;
  logic wrD;

  assign procStart = !procStrbN;
  assign ctlStart  = !ctlStrbN;
  assign anyStart  = procStart || ctlStart;
  assign chipSel   = !csAN && csB && !csCN;

  // Lane request: write-all overrides, byte selects need the byte enable
  always_comb begin
    if (!wrAllN)         laneReq = '1;
    else if (!byteWrEnN) laneReq = ~byteSelN;
    else                 laneReq = '0;
  end
  assign wrReq = |laneReq;

  always_comb begin
    strb = '0;
    selD = selQ;
    wrD  = 1'b0;
    if (anyStart) begin
      strb.load = 1'b1;
      selD      = chipSel;
      // processor strobe wins and always reads
      wrD       = chipSel && !procStart && wrReq;
    end else if (selQ) begin
      strb.step = !advanceN;
      wrD       = wrReq;
    end
    strb.wrEn = wrD;
    strb.ilv  = ilvMode;
    byteWe    = wrD ? laneReq : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selQ   <= 1'b0;
      wrCycQ <= 1'b0;
    end else begin
      selQ   <= selD;
      wrCycQ <= wrD;
    end
  end

  assign busOe = selQ && !wrCycQ && !outEnN;

endmodule

// File: rtl/syncBurstSramData.sv
module syncBurstSramData
  import syncBurstSramPkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int BYTES  = 4,
  parameter int BYTE_W = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ctrlStrobeT              strb,
  input  logic [BYTES-1:0]        byteWe,
  input  logic                    busOe,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [BYTES*BYTE_W-1:0] dataIn,
  output logic [BYTES*BYTE_W-1:0] dataOut,
  output logic [ADDR_W-1:0]       burstAddr
);

  localparam int DATA_W = BYTES * BYTE_W;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int UP_W   = ADDR_W - 2;

  logic [UP_W-1:0] upperQ, upperD;
  logic [1:0]      baseQ, baseD;
  logic [1:0]      beatQ, beatD;
  logic            ilvQ, ilvD;
  logic [ADDR_W-1:0] nextAddr;
  logic [DATA_W-1:0] rdData;

  always_comb begin
    upperD = upperQ;
    baseD  = baseQ;
    beatD  = beatQ;
    ilvD   = ilvQ;
    if (strb.load) begin
      upperD = addr[ADDR_W-1:2];
      baseD  = addr[1:0];
      beatD  = 2'd0;
      ilvD   = strb.ilv;
    end else if (strb.step) begin
      beatD  = beatQ + 2'd1;
    end
  end

  assign nextAddr  = {upperD, beatLow(baseD, beatD, ilvD)};
  assign burstAddr = {upperQ, beatLow(baseQ, beatQ, ilvQ)};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      upperQ <= '0;
      baseQ  <= '0;
      beatQ  <= '0;
      ilvQ   <= 1'b0;
    end else begin
      upperQ <= upperD;
      baseQ  <= baseD;
      beatQ  <= beatD;
      ilvQ   <= ilvD;
    end
  end

  // One storage array per byte lane
  for (genvar g = 0; g < BYTES; g++) begin : gLane
    logic [BYTE_W-1:0] lane [DEPTH];
    always_ff @(posedge clk) begin
      if (strb.wrEn && byteWe[g])
        lane[nextAddr] <= dataIn[g*BYTE_W +: BYTE_W];
    end
    assign rdData[g*BYTE_W +: BYTE_W] = lane[burstAddr];
  end

  assign dataOut = busOe ? rdData : '0;

endmodule

// File: rtl/syncBurstSram.sv
module syncBurstSram
  import syncBurstSramPkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int BYTES  = 4,
  parameter int BYTE_W = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    procStrbN,
  input  logic                    ctlStrbN,
  input  logic                    advanceN,
  input  logic                    csAN,
  input  logic                    csB,
  input  logic                    csCN,
  input  logic                    ilvMode,
  input  logic                    wrAllN,
  input  logic                    byteWrEnN,
  input  logic [BYTES-1:0]        byteSelN,
  input  logic                    outEnN,
  input  logic [BYTES*BYTE_W-1:0] dataIn,
  output logic [BYTES*BYTE_W-1:0] dataOut,
  output logic                    busOe
);

  ctrlStrobeT        strb;
  logic [BYTES-1:0]  byteWe;
  logic [ADDR_W-1:0] burstAddr;

  syncBurstSramCtrl #(.BYTES(BYTES)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .procStrbN(procStrbN), .ctlStrbN(ctlStrbN), .advanceN(advanceN),
    .csAN(csAN), .csB(csB), .csCN(csCN), .ilvMode(ilvMode),
    .wrAllN(wrAllN), .byteWrEnN(byteWrEnN), .byteSelN(byteSelN),
    .outEnN(outEnN), .strb(strb), .byteWe(byteWe), .busOe(busOe)
  );

  syncBurstSramData #(.ADDR_W(ADDR_W), .BYTES(BYTES), .BYTE_W(BYTE_W)) u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .byteWe(byteWe), .busOe(busOe),
    .addr(addr), .dataIn(dataIn), .dataOut(dataOut), .burstAddr(burstAddr)
  );

endmodule

// File: rtl/syncBurstSramChk.sv
module syncBurstSramChk
  import syncBurstSramPkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] addr,
  input logic              procStrbN,
  input logic              ctlStrbN,
  input logic              advanceN,
  input logic              csAN,
  input logic              csB,
  input logic              csCN,
  input logic              outEnN,
  input logic              busOe,
  input logic [ADDR_W-1:0] burstAddr,
  input ctrlStrobeT        strb
);

  p_addr_load_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!procStrbN || !ctlStrbN) |=> (burstAddr == $past(addr)));

  p_upper_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (procStrbN && ctlStrbN) |=> (burstAddr[ADDR_W-1:2] == $past(burstAddr[ADDR_W-1:2])));

  p_stall_r5: assert property (@(posedge clk) disable iff (!rstN)
    (procStrbN && ctlStrbN && advanceN) |=> $stable(burstAddr));

  p_proc_read_r8: assert property (@(posedge clk) disable iff (!rstN)
    !procStrbN |-> !strb.wrEn);

  p_oe_gate_r10: assert property (@(posedge clk) disable iff (!rstN)
    outEnN |-> !busOe);

  p_desel_r11: assert property (@(posedge clk) disable iff (!rstN)
    ((!procStrbN || !ctlStrbN) && !(!csAN && csB && !csCN)) |=> !busOe);

endmodule

bind syncBurstSram syncBurstSramChk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .addr(addr), .procStrbN(procStrbN),
  .ctlStrbN(ctlStrbN), .advanceN(advanceN), .csAN(csAN), .csB(csB),
  .csCN(csCN), .outEnN(outEnN), .busOe(busOe), .burstAddr(burstAddr),
  .strb(strb)
);

// File: tb/syncBurstSram_tb.sv
module syncBurstSram_tb;

  localparam int ADDR_W = 8;
  localparam int BYTES  = 4;
  localparam int BYTE_W = 8;
  localparam int DW     = BYTES * BYTE_W;
  localparam int NVEC   = 8;

  // {ilv, readViaController, startAddr}
  localparam logic [9:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 8'h10}, {1'b0, 1'b1, 8'h25}, {1'b0, 1'b0, 8'h3A},
    {1'b0, 1'b1, 8'h8F}, {1'b1, 1'b0, 8'h90}, {1'b1, 1'b1, 8'hA5},
    {1'b1, 1'b0, 8'hB6}, {1'b1, 1'b1, 8'hC7}
  };

  logic clk = 1'b0;
  logic rstN;
  logic [ADDR_W-1:0] addr;
  logic procStrbN, ctlStrbN, advanceN, csAN, csB, csCN, ilvMode;
  logic wrAllN, byteWrEnN, outEnN;
  logic [BYTES-1:0] byteSelN;
  logic [DW-1:0] dataIn, dataOut;
  logic busOe;

  logic [DW-1:0] refMem [1 << ADDR_W];
  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  syncBurstSram #(.ADDR_W(ADDR_W), .BYTES(BYTES), .BYTE_W(BYTE_W)) u_dut (
    .clk(clk), .rstN(rstN), .addr(addr), .procStrbN(procStrbN),
    .ctlStrbN(ctlStrbN), .advanceN(advanceN), .csAN(csAN), .csB(csB),
    .csCN(csCN), .ilvMode(ilvMode), .wrAllN(wrAllN), .byteWrEnN(byteWrEnN),
    .byteSelN(byteSelN), .outEnN(outEnN), .dataIn(dataIn),
    .dataOut(dataOut), .busOe(busOe)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #5;
  endtask

  task automatic idle();
    procStrbN = 1; ctlStrbN = 1; advanceN = 1;
    csAN = 0; csB = 1; csCN = 0;
    wrAllN = 1; byteWrEnN = 1; byteSelN = '1; outEnN = 0;
  endtask

  function automatic logic [7:0] seqAddr(input logic [7:0] a, input int n, input logic ilv);
    logic [1:0] b = 2'(n);
    return {a[7:2], ilv ? (a[1:0] ^ b) : (a[1:0] + b)};
  endfunction

  function automatic logic [DW-1:0] mix(input logic [7:0] a, input int n, input int salt);
    return {a ^ 8'(salt * 13), 8'(n * 17 + salt), ~a, 8'(salt + 8'h3C)};
  endfunction

  // Controller-strobe write burst of four beats with write-all
  task automatic writeBurst(input logic [7:0] a, input logic ilv, input int salt, input bit doChk);
    for (int n = 0; n < 4; n++) begin
      if (n == 0) begin ctlStrbN = 0; addr = a; ilvMode = ilv; end
      else begin ctlStrbN = 1; advanceN = 0; addr = ~a; ilvMode = ~ilv; end
      wrAllN = 0;
      dataIn = mix(a, n, salt);
      tick();
      refMem[seqAddr(a, n, ilv)] = mix(a, n, salt);
      if (doChk) chk("R10 drivers off after write edge", DW'(busOe), DW'(0));
    end
    idle();
    tick();
  endtask

  task automatic readBurst(input logic [7:0] a, input logic ilv, input bit viaCtl);
    if (viaCtl) ctlStrbN = 0; else procStrbN = 0;
    addr = a; ilvMode = ilv;
    tick();
    for (int n = 0; n < 4; n++) begin
      chk("R2 flow-through drive", DW'(busOe), DW'(1));
      if (ilv) chk("R4 interleaved beat", dataOut, refMem[seqAddr(a, n, 1'b1)]);
      else     chk("R3 linear beat", dataOut, refMem[seqAddr(a, n, 1'b0)]);
      procStrbN = 1; ctlStrbN = 1; advanceN = 0; addr = ~a;
      tick();
    end
    idle();
  endtask

  task automatic readOne(input logic [7:0] a, output logic [DW-1:0] d, output logic oe);
    procStrbN = 0; addr = a;
    tick();
    d = dataOut; oe = busOe;
    idle();
  endtask

  initial begin
    #(20 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [DW-1:0] d;
    logic oe;
    logic [DW-1:0] old;
    idle();
    addr = '0; ilvMode = 0; dataIn = '0;
    rstN = 0;
    tick(); tick();
    chk("R12 drivers off in reset", DW'(busOe), DW'(0));
    rstN = 1;
    tick();
    chk("R12 deselected after reset", DW'(busOe), DW'(0));
    chk("R12 bus zero after reset", dataOut, '0);

    // Fill the whole array with linear bursts
    for (int b = 0; b < 64; b++) writeBurst(8'(b * 4), 1'b0, b, (b == 0));

    // Table walk: all start offsets, both orders, both strobes
    for (int v = 0; v < NVEC; v++) begin
      writeBurst(VEC[v][7:0], VEC[v][9], 100 + v, 1'b0);
      readBurst(VEC[v][7:0], VEC[v][9], VEC[v][8]);
    end

    // R5 stall: advance held high keeps the word
    procStrbN = 0; addr = 8'h21; ilvMode = 0;
    tick();
    chk("R5 first beat", dataOut, refMem[8'h21]);
    procStrbN = 1; advanceN = 1;
    tick();
    chk("R5 stall holds word", dataOut, refMem[8'h21]);
    tick();
    chk("R5 second stall", dataOut, refMem[8'h21]);
    advanceN = 0;
    tick();
    chk("R5 resume advance", dataOut, refMem[8'h22]);
    idle(); tick();

    // R6 byte-masked write: lanes 0 and 2 (byteSelN bits low) written
    ctlStrbN = 0; addr = 8'h40; byteWrEnN = 0; byteSelN = 4'b1010; dataIn = 32'h11223344;
    tick();
    refMem[8'h40] = {refMem[8'h40][31:24], 8'h22, refMem[8'h40][15:8], 8'h44};
    idle();
    // R6 byte selects ignored without the byte enable
    ctlStrbN = 0; addr = 8'h41; byteWrEnN = 1; byteSelN = 4'b0000; dataIn = 32'hDEADBEEF;
    tick();
    chk("R6 no enable reads, drives", DW'(busOe), DW'(1));
    idle();
    readOne(8'h40, d, oe);
    chk("R6 masked lanes", d, refMem[8'h40]);
    readOne(8'h41, d, oe);
    chk("R6 selects ignored", d, refMem[8'h41]);

    // R7 write-all overrides byte selects
    ctlStrbN = 0; addr = 8'h42; wrAllN = 0; byteWrEnN = 0; byteSelN = 4'b1111; dataIn = 32'hA5A55A5A;
    tick();
    refMem[8'h42] = 32'hA5A55A5A;
    idle();
    readOne(8'h42, d, oe);
    chk("R7 all lanes written", d, 32'hA5A55A5A);

    // R8 processor start never writes; wins over controller strobe
    procStrbN = 0; addr = 8'h43; wrAllN = 0; dataIn = 32'h0BADF00D;
    tick();
    chk("R8 proc start reads", DW'(busOe), DW'(1));
    chk("R8 proc start old data", dataOut, refMem[8'h43]);
    idle();
    procStrbN = 0; ctlStrbN = 0; addr = 8'h44; wrAllN = 0; dataIn = 32'h0BADF00D;
    tick();
    chk("R8 both strobes read", dataOut, refMem[8'h44]);
    idle();
    readOne(8'h44, d, oe);
    chk("R8 both strobes no write", d, refMem[8'h44]);

    // R9 continuation writes at advanced and held addresses
    ctlStrbN = 0; addr = 8'h48; ilvMode = 0;
    tick();
    chk("R9 controller read start", dataOut, refMem[8'h48]);
    ctlStrbN = 1; advanceN = 0; wrAllN = 0; dataIn = 32'h49494949;
    tick();
    refMem[8'h49] = 32'h49494949;
    chk("R10 write cycle not driven", DW'(busOe), DW'(0));
    advanceN = 1; dataIn = 32'h4A4A0000;
    tick();
    refMem[8'h49] = 32'h4A4A0000;
    idle(); tick();
    chk("R9 held address rewritten", dataOut, 32'h4A4A0000);
    readOne(8'h48, d, oe);
    chk("R9 start word untouched", d, refMem[8'h48]);

    // R10 output enable acts without a clock
    procStrbN = 0; addr = 8'h42;
    tick();
    idle();
    outEnN = 1; #1;
    chk("R10 oe high disables", DW'(busOe), DW'(0));
    chk("R10 bus zero when off", dataOut, '0);
    outEnN = 0; #1;
    chk("R10 oe low drives", dataOut, 32'hA5A55A5A);
    tick();

    // R11 deselected start: no drive, writes ignored
    old = refMem[8'h50];
    ctlStrbN = 0; addr = 8'h50; csB = 0; wrAllN = 0; dataIn = 32'hFFFF0000;
    tick();
    chk("R11 deselect no drive", DW'(busOe), DW'(0));
    ctlStrbN = 1; csB = 1; advanceN = 0;
    tick();
    chk("R11 continuation ignored", DW'(busOe), DW'(0));
    idle();
    readOne(8'h50, d, oe);
    chk("R11 start address unwritten", d, old);
    readOne(8'h51, d, oe);
    chk("R11 next address unwritten", d, refMem[8'h51]);
    procStrbN = 0; addr = 8'h52; csAN = 1;
    tick();
    chk("R1 csAN high deselects", DW'(busOe), DW'(0));
    idle();

    // R13 order frozen at start: interleaved from 0x52 despite mode flip
    procStrbN = 0; addr = 8'h52; ilvMode = 1;
    tick();
    chk("R13 beat0", dataOut, refMem[8'h52]);
    procStrbN = 1; advanceN = 0; ilvMode = 0;
    tick();
    chk("R13 beat1", dataOut, refMem[8'h53]);
    tick();
    chk("R13 beat2", dataOut, refMem[8'h50]);
    tick();
    chk("R13 beat3", dataOut, refMem[8'h51]);
    tick();
    chk("R3 wraps within group", dataOut, refMem[8'h52]);
    idle(); tick();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule